// File: doc/BRIEF.md
# Dual-Use LFSR Pattern Source and Response Compactor

This block is a small linear feedback shift register for built-in self-test. In pattern mode it walks a fixed maximal-length pseudorandom order of 15 non-zero words. Every sequence starts from a seed that can be loaded, and each word can drive the inputs of a logic block under test. In signature mode the same register takes a parallel response word from that logic block on every clock and folds it into its stages. After a run of known stimulus, the final contents are a compact signature.

The register shifts from its most significant stage toward its least significant one. The new top bit is the XOR of the top and bottom stages. A synchronous clear puts the register in a mode-dependent start state. A zero seed in pattern mode would lock the register, so the block replaces it with the default seed and reports the substitution. A one-cycle flag marks each return of the pattern sequence to its seed.

Top module: `lfsr_patsig`

## Requirements
- R1: While the asynchronous active-low reset `rst_ni` is low, `state_o` is 4'b1000 and both `wrap_o` and `seed_err_o` are 0.
- R2: In pattern mode (`mode_i`=0), with `clr_i` and `load_i` low, each clock moves the register from {x3,x2,x1,x0} to {x3^x0,x3,x2,x1}. From 1000 the order is 1000, 1100, 1110, 1111, 0111, 1011, 0101, 1010, 1101, 0110, 0011, 1001, 0100, 0010, 0001.
- R3: In pattern mode the sequence from any non-zero seed returns to that seed after exactly 15 steps, and it visits no all-zero state.
- R4: In signature mode (`mode_i`=1), with `clr_i` and `load_i` low, the next state is {x3^x0^p3, x3^p2, x2^p1, x1^p0}, where p3..p0 is `resp_i`.
- R5: `clr_i` has priority over `load_i`. On the next clock it sets `state_o` to 4'b0000 in signature mode and to 4'b1000 in pattern mode, and it sets the stored seed to 4'b1000.
- R6: With `load_i` high and `clr_i` low, `seed_i` appears on `state_o` after the next clock and becomes the stored seed. The exception is a pattern-mode load of 4'b0000: it puts 4'b1000 in the register and the stored seed, and it raises `seed_err_o` for exactly one cycle.
- R7: `wrap_o` is high for one cycle, in the cycle where a pattern-mode step has brought `state_o` back to the stored seed. A load or clear never raises it.
- R8: In signature mode a load of 4'b0000 is accepted as is and does not raise `seed_err_o`.
- R9: In pattern mode `resp_i` has no effect on `state_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear to the mode-dependent start state |
| mode_i | input | 1 | 0 = pattern mode, 1 = signature mode |
| load_i | input | 1 | Load `seed_i` on the next clock |
| seed_i | input | 4 | Seed value |
| resp_i | input | 4 | Parallel response word from the logic under test |
| state_o | output | 4 | Current pattern or signature |
| wrap_o | output | 1 | One-cycle pulse when the pattern sequence is back at the seed |
| seed_err_o | output | 1 | One-cycle pulse when a zero seed was replaced in pattern mode |

## Verification
Some properties are checked on every clock. A non-zero pattern state never decays to zero. A wrap pulse only appears while the register holds the stored seed, and it never lasts two cycles. A seed error always leaves the default seed in place. A clear in signature mode empties the register.

Other behaviour only the bench scenarios can show. These are the exact 15-word order, the wrap pulse landing on the fifteenth step from both the default seed and a loaded one, and the signature values built from chosen response words. They also include clear-over-load priority, the ignored response input in pattern mode, and the zero-seed cases in both modes.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_SIG = 1'b1
  } lfsr_mode_e;

endpackage

// File: rtl/lfsr_step.sv
module lfsr_step #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] resp_i,
  input  logic         fold_i,
  output logic [W-1:0] nxt_o
);

  logic [W-1:0] inj;
  logic         fb;

  assign inj = fold_i ? resp_i : '0;
  assign fb  = cur_i[W-1] ^ cur_i[0];

  // top stage takes the feedback, the others take their upper neighbour
  assign nxt_o[W-1] = fb ^ inj[W-1];

  for (genvar i = 0; i < W-1; i++) begin : g_shift
    assign nxt_o[i] = cur_i[i+1] ^ inj[i];
  end

endmodule

// File: rtl/lfsr_flags.sv
module lfsr_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_set_i,
  input  logic err_set_i,
  output logic wrap_o,
  output logic err_o
);

  logic wrap_d, wrap_q;
  logic err_d, err_q;

  always_comb begin
    wrap_d = wrap_set_i;
    err_d  = err_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrap_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      wrap_q <= wrap_d;
      err_q  <= err_d;
    end
  end

  assign wrap_o = wrap_q;
  assign err_o  = err_q;

  // R7
  wrap_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);

endmodule

// File: rtl/lfsr_patsig.sv
module lfsr_patsig #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         mode_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic [W-1:0] resp_i,
  output logic [W-1:0] state_o,
  output logic         wrap_o,
  output logic         seed_err_o
);

  localparam logic [W-1:0] DEF_SEED = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ZERO     = '0;

  logic         is_sig;
  logic [W-1:0] state_d, state_q;
  logic [W-1:0] seed_d, seed_q;
  logic [W-1:0] step_nxt;
  logic         stepped;
  logic         zero_fix;
  logic         wrap_set;

  assign is_sig = (mode_i == lfsr_pkg::MODE_SIG);

  lfsr_step #(.W(W)) step_i (
    .cur_i  (state_q),
    .resp_i (resp_i),
    .fold_i (is_sig),
    .nxt_o  (step_nxt)
  );

  // next-state selection: clear, then load, then step
  always_comb begin
    state_d  = step_nxt;
    seed_d   = seed_q;
    stepped  = 1'b1;
    zero_fix = 1'b0;
    if (clr_i) begin
      state_d = is_sig ? ZERO : DEF_SEED;
      seed_d  = DEF_SEED;
      stepped = 1'b0;
    end else if (load_i) begin
      stepped = 1'b0;
      if (!is_sig && (seed_i == ZERO)) begin
        state_d  = DEF_SEED;
        seed_d   = DEF_SEED;
        zero_fix = 1'b1;
      end else begin
        state_d = seed_i;
        seed_d  = seed_i;
      end
    end
  end

  assign wrap_set = stepped && !is_sig && (step_nxt == seed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DEF_SEED;
      seed_q  <= DEF_SEED;
    end else begin
      state_q <= state_d;
      seed_q  <= seed_d;
    end
  end

  lfsr_flags flags_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wrap_set_i (wrap_set),
    .err_set_i  (zero_fix),
    .wrap_o     (wrap_o),
    .err_o      (seed_err_o)
  );

  assign state_o = state_q;

  // R7
  wrap_at_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (state_o == seed_q));

  // R6
  err_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_err_o |-> (state_o == DEF_SEED));

  // R3
  gen_no_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && !is_sig && (state_o != ZERO)) |=> (state_o != ZERO));

  // R5
  clr_sig_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && is_sig) |=> (state_o == ZERO));

endmodule

// File: tb/lfsr_patsig_tb_top.sv
module lfsr_patsig_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       clr_i, mode_i, load_i;
  logic [3:0] seed_i, resp_i;
  logic [3:0] state_o;
  logic       wrap_o, seed_err_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  lfsr_patsig #(.W(4)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .mode_i     (mode_i),
    .load_i     (load_i),
    .seed_i     (seed_i),
    .resp_i     (resp_i),
    .state_o    (state_o),
    .wrap_o     (wrap_o),
    .seed_err_o (seed_err_o)
  );

  // {clr, mode, load, seed[4], resp[4], exp_state[4], exp_wrap, exp_err}
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'b0000, 4'b1111, 4'b1100, 1'b0, 1'b0}, // R9 R2
    {1'b0, 1'b0, 1'b0, 4'b0000, 4'b0101, 4'b1110, 1'b0, 1'b0}, // R9 R2
    {1'b0, 1'b0, 1'b1, 4'b0101, 4'b0000, 4'b0101, 1'b0, 1'b0}, // R6
    {1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 4'b1010, 1'b0, 1'b0}, // R2
    {1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 4'b1101, 1'b0, 1'b0}, // R2
    {1'b0, 1'b0, 1'b1, 4'b0000, 4'b0000, 4'b1000, 1'b0, 1'b1}, // R6
    {1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 4'b1100, 1'b0, 1'b0}, // R6
    {1'b1, 1'b0, 1'b1, 4'b0011, 4'b0000, 4'b1000, 1'b0, 1'b0}, // R5
    {1'b1, 1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R5
    {1'b0, 1'b1, 1'b0, 4'b0000, 4'b1010, 4'b1010, 1'b0, 1'b0}, // R4
    {1'b0, 1'b1, 1'b0, 4'b0000, 4'b0001, 4'b1100, 1'b0, 1'b0}, // R4
    {1'b0, 1'b1, 1'b0, 4'b0000, 4'b0110, 4'b1000, 1'b0, 1'b0}, // R4
    {1'b0, 1'b1, 1'b1, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R8
    {1'b0, 1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}  // R4
  };

  function automatic logic [3:0] gen_model(input logic [3:0] s);
    return {s[3] ^ s[0], s[3:1]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic c, input logic m, input logic l,
                       input logic [3:0] sd, input logic [3:0] rp);
    clr_i  = c;
    mode_i = m;
    load_i = l;
    seed_i = sd;
    resp_i = rp;
    @(posedge clk_i);
    #1;
  endtask

  task automatic full_cycle(input string tag, input logic [3:0] start);
    logic [3:0] exp_s;
    exp_s = start;
    for (int k = 1; k <= 15; k++) begin
      apply(1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000);
      exp_s = gen_model(exp_s);
      chk({tag, " state"}, int'(state_o), int'(exp_s));
      chk({tag, " wrap"}, int'(wrap_o), (k == 15) ? 1 : 0);
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    rst_ni = 1'b0;
    clr_i  = 1'b0;
    mode_i = 1'b0;
    load_i = 1'b0;
    seed_i = 4'b0000;
    resp_i = 4'b0000;
    #23;
    // R1 reset state
    chk("R1 state", int'(state_o), 8);
    chk("R1 wrap", int'(wrap_o), 0);
    chk("R1 err", int'(seed_err_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13:10], VEC[i][9:6]);
      chk($sformatf("vec%0d state", i), int'(state_o), int'(VEC[i][5:2]));
      chk($sformatf("vec%0d wrap", i), int'(wrap_o), int'(VEC[i][1]));
      chk($sformatf("vec%0d err", i), int'(seed_err_o), int'(VEC[i][0]));
    end

    // R5 clear in pattern mode, then R3 R7 full period from default seed
    apply(1'b1, 1'b0, 1'b0, 4'b0000, 4'b0000);
    chk("R5 clr gen", int'(state_o), 8);
    chk("R7 no wrap on clr", int'(wrap_o), 0);
    full_cycle("R3 R7 default", 4'b1000);

    // R7 loaded seed, full period
    apply(1'b0, 1'b0, 1'b1, 4'b0110, 4'b0000);
    chk("R6 load 0110", int'(state_o), 6);
    chk("R7 no wrap on load", int'(wrap_o), 0);
    full_cycle("R3 R7 seed0110", 4'b0110);

    // R7 reloading the current value gives no wrap
    apply(1'b0, 1'b0, 1'b1, 4'b0110, 4'b0000);
    chk("R7 reload same", int'(wrap_o), 0);

    // R1 asynchronous reset in mid-cycle
    #2;
    rst_ni = 1'b0;
    #1;
    chk("R1 async state", int'(state_o), 8);
    chk("R1 async wrap", int'(wrap_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule